// File: doc/BRIEF.md
# Serial Port FIFO Interrupt Logic

This block holds the transmit and receive FIFOs of a synchronous serial port and raises an interrupt from four conditions. Two conditions follow the FIFO fill levels: receive at least half full, and transmit at least half empty. Two are sticky events. The first is a receive overrun: a frame completes while the receive FIFO is full, and the new frame replaces the newest stored entry. The second is a receive timeout: the receive FIFO holds data, but no frame has arrived and no entry has been read for 32 serial bit periods.

Software uses a byte-wide register bus to read and write a mask, to read the raw and masked status, and to clear the sticky events. The single interrupt output is registered. All FIFO ports are valid/ready streams, with one exception. The receive input has no ready: a frame is always taken, and a full FIFO overwrites its newest entry instead of stalling. The transmit input drops its ready while the transmit FIFO is full. Both outputs present data while their FIFO is non-empty, and one entry leaves on each cycle where valid and ready are both high.

Top module: `ser_irq_unit`

## Requirements
- R1: After reset the mask reads 0x00, the raw status reads 0x08 (only bit 3 set), the masked status reads 0x00 and irq is low.
- R2: Register map on `reg_addr`: mask at 0x14 (bits 3:0), raw status at 0x18, masked status at 0x1C, clear at 0x20 (write-only, reads 0). Any other address reads 0. Bits 7:4 always read 0, and writes to them are ignored.
- R3: Raw bit 2 is 1 exactly while the receive level is at least DEPTH/2 (4 with defaults).
- R4: Raw bit 3 is 1 exactly while the transmit level is at most DEPTH/2.
- R5: If a receive frame arrives while the receive FIFO is full and is not read in that cycle, raw bit 0 becomes 1. The frame replaces the most recently stored entry, and the level stays at DEPTH.
- R6: Raw bit 1 becomes 1 on the 32*BIT_CLKS-th consecutive clock edge with a non-empty receive FIFO and no receive push or read. Any receive push or read restarts the count, and the bit never sets while the FIFO is empty.
- R7: Raw bits 0 and 1 hold until a write to the clear address with a 1 in the matching bit. Clear writes to bits 2 and 3 have no effect.
- R8: The masked status equals raw status AND mask.
- R9: irq is the OR of the masked status bits, delayed by one clock.
- R10: Both FIFOs keep first-in first-out order. tx_in_ready is low while the transmit FIFO holds DEPTH entries, and a push offered then is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_in_valid | input | 1 | Transmit write stream valid |
| tx_in_ready | output | 1 | Transmit FIFO has room |
| tx_in_data | input | W | Transmit word |
| tx_out_valid | output | 1 | Transmit FIFO non-empty, toward shifter |
| tx_out_ready | input | 1 | Shifter takes a word |
| tx_out_data | output | W | Oldest transmit word |
| rx_in_valid | input | 1 | Frame complete from shifter |
| rx_in_data | input | W | Received frame |
| rx_out_valid | output | 1 | Receive FIFO non-empty |
| rx_out_ready | input | 1 | Reader takes a word |
| rx_out_data | output | W | Oldest received word |
| tx_level | output | $clog2(DEPTH)+1 | Transmit FIFO entry count |
| rx_level | output | $clog2(DEPTH)+1 | Receive FIFO entry count |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Combined interrupt |

## Verification
The main function is tried with a table of fill patterns. Each pattern pairs a receive count and a transmit count with a mask. Counts fall on both sides of DEPTH/2 and at exactly DEPTH/2, which separates the two level conditions and catches an off-by-one in either compare. Masks that enable only some bits set the masked view and irq apart from the raw view. Directed sequences push a ninth frame into a full receive FIFO and then drain it, which tells overwrite-newest apart from drop and from overwrite-oldest. A restarted idle count shows that the timeout depends on the last activity and not on the first frame.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int RA_W = 6;
  localparam int RD_W = 8;
  localparam logic [RA_W-1:0] ADR_MASK  = 6'h14;
  localparam logic [RA_W-1:0] ADR_RAW   = 6'h18;
  localparam logic [RA_W-1:0] ADR_MIS   = 6'h1C;
  localparam logic [RA_W-1:0] ADR_CLR   = 6'h20;
  localparam int NSRC = 4;
  // bit positions of the interrupt sources
  localparam int B_OVR = 0;
  localparam int B_TMO = 1;
  localparam int B_RXH = 2;
  localparam int B_TXH = 3;
endpackage

// File: rtl/sirq_fifo.sv
module sirq_fifo #(
  parameter int W         = 16,
  parameter int DEPTH     = 8,
  parameter bit OVERWRITE = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [W-1:0]               in_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [W-1:0]               out_data,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       ovw
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full, push, pop, store;

  assign full      = (cnt == CW'(DEPTH));
  assign out_valid = (cnt != '0);
  assign pop       = out_valid && out_ready;

  generate
    if (OVERWRITE) begin : g_ovw
      assign in_ready = 1'b1;
      assign ovw      = in_valid && full && !pop;
    end else begin : g_bp
      assign in_ready = !full;
      assign ovw      = 1'b0;
    end
  endgenerate

  assign push  = in_valid && in_ready;
  assign store = push && !ovw;

  always_ff @(posedge clk) begin
    if (store)    mem[wp]      <= in_data;
    else if (ovw) mem[wp - 1'b1] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (store) wp <= wp + 1'b1;
      if (pop)   rp <= rp + 1'b1;
      case ({store, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign out_data = mem[rp];
  assign level    = cnt;

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R10
  order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !(ovw && cnt == CW'(1))) |=> $stable(out_data));
endmodule

// File: rtl/sirq_rx_timer.sv
module sirq_rx_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic nonempty,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (active || !nonempty) cnt <= '0;
    else if (cnt != CW'(LIMIT))   cnt <= cnt + 1'b1;
  end

  assign hit = nonempty && !active && (cnt == CW'(LIMIT - 1));

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> (cnt == '0));
endmodule

// File: rtl/sirq_regs.sv
module sirq_regs
  import sirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ovr_set,
  input  logic            tmo_set,
  input  logic            rx_half,
  input  logic            tx_half,
  input  logic            reg_wr,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [RD_W-1:0] reg_wdata,
  output logic [RD_W-1:0] reg_rdata,
  output logic [NSRC-1:0] raw,
  output logic            irq
);
  logic [NSRC-1:0] mask, mis;
  logic            ovr_q, tmo_q, clr_wr, msk_wr;
  logic [RD_W-NSRC-1:0] unused_hi;

  assign unused_hi = reg_wdata[RD_W-1:NSRC];
  assign clr_wr = reg_wr && (reg_addr == ADR_CLR);
  assign msk_wr = reg_wr && (reg_addr == ADR_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask  <= '0;
      ovr_q <= 1'b0;
      tmo_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (msk_wr) mask <= reg_wdata[NSRC-1:0];
      if (ovr_set)                     ovr_q <= 1'b1;
      else if (clr_wr && reg_wdata[B_OVR]) ovr_q <= 1'b0;
      if (tmo_set)                     tmo_q <= 1'b1;
      else if (clr_wr && reg_wdata[B_TMO]) tmo_q <= 1'b0;
      irq <= |mis;
    end
  end

  always_comb begin
    raw        = '0;
    raw[B_OVR] = ovr_q;
    raw[B_TMO] = tmo_q;
    raw[B_RXH] = rx_half;
    raw[B_TXH] = tx_half;
  end
  assign mis = raw & mask;

  always_comb begin
    case (reg_addr)
      ADR_MASK: reg_rdata = {{(RD_W-NSRC){1'b0}}, mask};
      ADR_RAW:  reg_rdata = {{(RD_W-NSRC){1'b0}}, raw};
      ADR_MIS:  reg_rdata = {{(RD_W-NSRC){1'b0}}, mis};
      default:  reg_rdata = '0;
    endcase
  end

  // R7
  sticky_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_q && !(clr_wr && reg_wdata[B_TMO])) |=> tmo_q);

  // R7
  sticky_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !(clr_wr && reg_wdata[B_OVR])) |=> ovr_q);
endmodule

// File: rtl/ser_irq_unit.sv
module ser_irq_unit
  import sirq_pkg::*;
#(
  parameter int W        = 16,
  parameter int DEPTH    = 8,
  parameter int BIT_CLKS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tx_in_valid,
  output logic                      tx_in_ready,
  input  logic [W-1:0]              tx_in_data,
  output logic                      tx_out_valid,
  input  logic                      tx_out_ready,
  output logic [W-1:0]              tx_out_data,
  input  logic                      rx_in_valid,
  input  logic [W-1:0]              rx_in_data,
  output logic                      rx_out_valid,
  input  logic                      rx_out_ready,
  output logic [W-1:0]              rx_out_data,
  output logic [$clog2(DEPTH):0]    tx_level,
  output logic [$clog2(DEPTH):0]    rx_level,
  input  logic                      reg_wr,
  input  logic [5:0]                reg_addr,
  input  logic [7:0]                reg_wdata,
  output logic [7:0]                reg_rdata,
  output logic                      irq
);
  localparam int CW    = $clog2(DEPTH) + 1;
  localparam int HALF  = DEPTH / 2;
  localparam int LIMIT = 32 * BIT_CLKS;

  logic rx_in_ready, tx_ovw, rx_ovw, tmo_hit, rx_act;
  logic rx_half, tx_half;
  logic [NSRC-1:0] raw;

  sirq_fifo #(.W(W), .DEPTH(DEPTH), .OVERWRITE(1'b0)) u_txf (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_data(tx_out_data),
    .level(tx_level), .ovw(tx_ovw));

  sirq_fifo #(.W(W), .DEPTH(DEPTH), .OVERWRITE(1'b1)) u_rxf (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_data(rx_in_data),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready), .out_data(rx_out_data),
    .level(rx_level), .ovw(rx_ovw));

  assign rx_act = rx_in_valid || (rx_out_valid && rx_out_ready);

  sirq_rx_timer #(.LIMIT(LIMIT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .active(rx_act),
    .nonempty(rx_out_valid), .hit(tmo_hit));

  assign rx_half = (rx_level >= CW'(HALF));
  assign tx_half = (tx_level <= CW'(HALF));

  sirq_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .ovr_set(rx_ovw), .tmo_set(tmo_hit),
    .rx_half(rx_half), .tx_half(tx_half),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .raw(raw), .irq(irq));

  // R5
  ovr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_level == CW'(DEPTH) && !rx_out_ready) |=> raw[B_OVR]);

  // R5
  ovr_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_level == CW'(DEPTH) && !rx_out_ready) |=> (rx_level == CW'(DEPTH)));

  // R6
  tmo_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw[B_TMO]) |-> ($past(rx_level) != '0));

  // R10
  tx_bp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == CW'(DEPTH)) |-> !tx_in_ready);

  logic unused_flags;
  assign unused_flags = rx_in_ready ^ tx_ovw;
endmodule

// File: tb/sim_ser_irq_unit.sv
module sim_ser_irq_unit;
  localparam int CLK_NS   = 10;
  localparam int W        = 16;
  localparam int DEPTH    = 8;
  localparam int BIT_CLKS = 2;
  localparam int LIMIT    = 32 * BIT_CLKS;
  localparam int LW       = $clog2(DEPTH) + 1;

  logic clk = 0, rst_n = 0;
  logic tx_in_valid = 0, tx_out_ready = 0, rx_in_valid = 0, rx_out_ready = 0;
  logic [W-1:0] tx_in_data = '0, rx_in_data = '0;
  logic tx_in_ready, tx_out_valid, rx_out_valid, irq;
  logic [W-1:0] tx_out_data, rx_out_data;
  logic [LW-1:0] tx_level, rx_level;
  logic reg_wr = 0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;

  int checks = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  ser_irq_unit #(.W(W), .DEPTH(DEPTH), .BIT_CLKS(BIT_CLKS)) u0 (.*);

  // {rx pushes, tx pushes, mask, expected raw, expected masked}
  typedef struct packed { logic [7:0] nrx, ntx, msk, eraw, emis; } vec_t;
  localparam vec_t VECS [7] = '{
    '{8'd0, 8'd0, 8'h0F, 8'h08, 8'h08},
    '{8'd3, 8'd0, 8'h0F, 8'h08, 8'h08},
    '{8'd4, 8'd0, 8'h0F, 8'h0C, 8'h0C},
    '{8'd4, 8'd4, 8'h04, 8'h0C, 8'h04},
    '{8'd0, 8'd5, 8'h0F, 8'h00, 8'h00},
    '{8'd8, 8'd8, 8'h03, 8'h04, 8'h00},
    '{8'd2, 8'd3, 8'h08, 8'h08, 8'h08}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; tx_in_valid = 0; rx_in_valid = 0; tx_out_ready = 0;
    rx_out_ready = 0; reg_wr = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rx_push(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      rx_in_valid = 1; rx_in_data = W'(base + i);
      @(negedge clk);
    end
    rx_in_valid = 0;
  endtask

  task automatic tx_push(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      tx_in_valid = 1; tx_in_data = W'(base + i);
      @(negedge clk);
    end
    tx_in_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    do_reset();
    // R1 reset state
    rd(6'h14, v); chk("R1 mask", v, 8'h00);
    rd(6'h18, v); chk("R1 raw", v, 8'h08);
    rd(6'h1C, v); chk("R1 masked", v, 8'h00);
    chk("R1 irq", irq, 0);

    // R3 R4 R8 R9 vector table
    foreach (VECS[k]) begin
      do_reset();
      rx_push(VECS[k].nrx, 16'h100);
      tx_push(VECS[k].ntx, 16'h200);
      wr(6'h14, VECS[k].msk);
      rd(6'h18, v); chk("R3/R4 raw vector", v, VECS[k].eraw);
      rd(6'h1C, v); chk("R8 masked vector", v, VECS[k].emis);
      @(negedge clk);
      chk("R9 irq vector", irq, VECS[k].emis != 0);
    end

    // R2 reserved bits, unmapped and clear reads
    do_reset();
    wr(6'h14, 8'hF2);
    rd(6'h14, v); chk("R2 mask reserved", v, 8'h02);
    rd(6'h20, v); chk("R2 clear reads 0", v, 8'h00);
    rd(6'h04, v); chk("R2 unmapped", v, 8'h00);

    // R9 latency: mask bit 3 while tx empty
    do_reset();
    wr(6'h14, 8'h08);
    chk("R9 irq not yet", irq, 0);
    @(negedge clk);
    chk("R9 irq after one cycle", irq, 1);

    // R5 overrun, R7 sticky and level bits not clearable
    do_reset();
    rx_push(DEPTH + 1, 1);
    rx_in_data = '0;
    chk("R5 level stays full", rx_level, DEPTH);
    rd(6'h18, v); chk("R5 overrun flag", v, 8'h0D);
    wr(6'h20, 8'h0E);
    rd(6'h18, v); chk("R7 level bits not cleared", v, 8'h0D);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R5 rx valid", rx_out_valid, 1);
      chk("R5 rx order", rx_out_data, (i == DEPTH-1) ? DEPTH + 1 : i + 1);
      rx_out_ready = 1; @(negedge clk); rx_out_ready = 0;
    end
    rd(6'h18, v); chk("R7 overrun sticky after drain", v, 8'h09);
    wr(6'h20, 8'h01);
    rd(6'h18, v); chk("R7 overrun cleared", v, 8'h08);

    // R10 tx back-pressure and order
    do_reset();
    tx_push(DEPTH, 16'h50);
    chk("R10 tx ready low", tx_in_ready, 0);
    tx_push(1, 16'hEE);
    chk("R10 tx level", tx_level, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R10 tx order", tx_out_data, 16'h50 + i);
      tx_out_ready = 1; @(negedge clk); tx_out_ready = 0;
    end
    chk("R10 tx empty", tx_out_valid, 0);

    // R6 timeout: not while empty, restart, exact count
    do_reset();
    repeat (LIMIT + 10) @(negedge clk);
    rd(6'h18, v); chk("R6 no timeout when empty", v & 8'h02, 0);
    rx_push(1, 7);
    repeat (40) @(negedge clk);
    rx_push(1, 8);
    repeat (LIMIT - 1) @(negedge clk);
    rd(6'h18, v); chk("R6 not before limit", v & 8'h02, 0);
    @(negedge clk);
    rd(6'h18, v); chk("R6 timeout at limit", v & 8'h02, 8'h02);
    wr(6'h20, 8'h01);
    rd(6'h18, v); chk("R7 timeout sticky", v & 8'h02, 8'h02);
    wr(6'h20, 8'h02);
    rd(6'h18, v); chk("R7 timeout cleared", v & 8'h02, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule